// File: doc/BRIEF.md
# Cascadable 32-Source Interrupt Controller

This block collects 32 interrupt request lines and turns them into two processor requests, one for ordinary service and one for critical service. Every line can be set to respond to a level or to an edge, with a selectable sense. It has a pending bit, an enable bit and a routing bit that picks which of the two processor requests it drives. Software reaches all of this through a small word-addressed register bus. Each bus access completes in the cycle it is presented, so there is no handshake and no back-pressure: a write takes effect at the next rising clock and read data is valid combinationally while the read strobe is high.

Software clears pending bits by writing ones. It reads the masked-status word, which is pending AND enabled, and services the source whose bit is highest first, because source 0 is the most significant bit. The request outputs are plain level signals. Either one may drive an input line of a second instance, which builds a two-level cascade.

Top module: `irq_hub32`

## Requirements
- R1: Source n drives input bit 31-n and occupies bit 31-n of every per-source register. The word offsets are: pending status 0x0, enable 0x2, critical routing 0x3, sense 0x4, trigger mode 0x5, masked status 0x6.
- R2: After reset, enable, critical routing, trigger mode and pending status are all zero, sense is all ones, and both request outputs are low.
- R3: A write to offset 0x0 clears each pending bit written as 1 and leaves each bit written as 0 unchanged.
- R4: With trigger bit 1 (edge), sense 1 sets pending on a rising input and sense 0 sets it on a falling input. Each input passes through two synchroniser flops, so the pending bit reads set after the third rising clock following the input change. A steady input does not set the bit again after it is cleared.
- R5: With trigger bit 0 (level), pending is set in every cycle the synchronised input is at its active level (high for sense 1, low for sense 0). A clear therefore has no lasting effect while the input stays active, even when the source is disabled.
- R6: Pending bits are recorded whether or not the source is enabled. When a hardware set and a software clear hit the same bit in the same cycle, the bit ends set.
- R7: Offset 0x6 reads as pending AND enable. It is read-only: writes to it change no state.
- R8: The ordinary request output is the registered OR of masked bits whose routing bit is 0. The critical request output is the registered OR of masked bits whose routing bit is 1. Each follows the pending and enable state one clock later.
- R9: Offsets 0x1, 0x7 and 0x8 through 0xF read as zero, and writes to them change no state.
- R10: The read data bus is zero whenever the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| irq_src_i | input | 32 | Raw request lines, bit 31-n is source n |
| reg_addr_i | input | 4 | Register word offset |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, zero when not reading |
| irq_noncrit_o | output | 1 | Ordinary processor request |
| irq_crit_o | output | 1 | Critical processor request |

## Verification
Some properties are checked on every cycle. These are the idle-zero read bus, the zero reads of unmapped offsets, and the rule that masked-status reads show only bits that are both pending and enabled. Two more are also checked each cycle: a level source active in the previous cycle is pending now, and both requests stay low after a cycle with no source enabled. Other behaviour needs a chosen sequence of stimuli: edge versus level response and the three-clock capture latency, the separate effect of write-one and write-zero on a clear, a set winning against a clear issued in the same cycle, and writes to the masked and unmapped offsets leaving the configuration intact. The bench scenarios build those sequences and compare every cycle against a behavioural model.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int NSRC   = 32;
  localparam int REG_AW = 4;

  localparam logic [3:0] OFS_STAT   = 4'h0;
  localparam logic [3:0] OFS_EN     = 4'h2;
  localparam logic [3:0] OFS_CRIT   = 4'h3;
  localparam logic [3:0] OFS_POL    = 4'h4;
  localparam logic [3:0] OFS_TRIG   = 4'h5;
  localparam logic [3:0] OFS_MASKED = 4'h6;
endpackage

// File: rtl/irq_hub_sync.sv
module irq_hub_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] prev_o
);
  logic [STAGES-1:0][W-1:0] pipe_q;
  logic [W-1:0]             prev_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      pipe_q <= '0;
      prev_q <= '0;
    end else begin
      pipe_q[0] <= d_i;
      for (int k = 1; k < STAGES; k++) pipe_q[k] <= pipe_q[k-1];
      prev_q <= pipe_q[STAGES-1];
    end
  end

  assign q_o    = pipe_q[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/irq_hub_detect.sv
module irq_hub_detect #(
  parameter int W = 32
) (
  input  logic [W-1:0] sync_i,
  input  logic [W-1:0] prev_i,
  input  logic [W-1:0] trig_i,
  input  logic [W-1:0] pol_i,
  output logic [W-1:0] set_o
);
  genvar g;
  for (g = 0; g < W; g++) begin : g_src
    logic rise, fall, edge_hit, lvl_act;
    assign rise     = sync_i[g] & ~prev_i[g];
    assign fall     = ~sync_i[g] & prev_i[g];
    assign edge_hit = pol_i[g] ? rise : fall;
    assign lvl_act  = ~(sync_i[g] ^ pol_i[g]);
    assign set_o[g] = trig_i[g] ? edge_hit : lvl_act;
  end
endmodule

// File: rtl/irq_hub_regs.sv
module irq_hub_regs
  import irq_hub_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [W-1:0]  set_i,
  output logic [W-1:0]  rdata_o,
  output logic [W-1:0]  status_o,
  output logic [W-1:0]  enable_o,
  output logic [W-1:0]  crit_o,
  output logic [W-1:0]  pol_o,
  output logic [W-1:0]  trig_o
);
  logic [W-1:0] status_q, enable_q, crit_q, pol_q, trig_q, clr;
  logic hit_stat, hit_en, hit_crit, hit_pol, hit_trig;

  assign hit_stat = wr_i && (addr_i == AW'(OFS_STAT));
  assign hit_en   = wr_i && (addr_i == AW'(OFS_EN));
  assign hit_crit = wr_i && (addr_i == AW'(OFS_CRIT));
  assign hit_pol  = wr_i && (addr_i == AW'(OFS_POL));
  assign hit_trig = wr_i && (addr_i == AW'(OFS_TRIG));
  assign clr      = hit_stat ? wdata_i : '0;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      status_q <= '0;
      enable_q <= '0;
      crit_q   <= '0;
      pol_q    <= '1;
      trig_q   <= '0;
    end else begin
      status_q <= (status_q & ~clr) | set_i;
      if (hit_en)   enable_q <= wdata_i;
      if (hit_crit) crit_q   <= wdata_i;
      if (hit_pol)  pol_q    <= wdata_i;
      if (hit_trig) trig_q   <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      case (addr_i)
        AW'(OFS_STAT):   rdata_o = status_q;
        AW'(OFS_EN):     rdata_o = enable_q;
        AW'(OFS_CRIT):   rdata_o = crit_q;
        AW'(OFS_POL):    rdata_o = pol_q;
        AW'(OFS_TRIG):   rdata_o = trig_q;
        AW'(OFS_MASKED): rdata_o = status_q & enable_q;
        default:         rdata_o = '0;
      endcase
    end
  end

  assign status_o = status_q;
  assign enable_o = enable_q;
  assign crit_o   = crit_q;
  assign pol_o    = pol_q;
  assign trig_o   = trig_q;
endmodule

// File: rtl/irq_hub_outs.sv
module irq_hub_outs #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] status_i,
  input  logic [W-1:0] enable_i,
  input  logic [W-1:0] crit_i,
  output logic         noncrit_o,
  output logic         crit_o
);
  logic [W-1:0] masked;
  logic         nc_q, c_q;

  assign masked = status_i & enable_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      nc_q <= 1'b0;
      c_q  <= 1'b0;
    end else begin
      nc_q <= |(masked & ~crit_i);
      c_q  <= |(masked & crit_i);
    end
  end

  assign noncrit_o = nc_q;
  assign crit_o    = c_q;
endmodule

// File: rtl/irq_hub32.sv
module irq_hub32
  import irq_hub_pkg::*;
#(
  parameter int NS          = NSRC,
  parameter int AW          = REG_AW,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NS-1:0] irq_src_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic          reg_wr_i,
  input  logic          reg_rd_i,
  input  logic [NS-1:0] reg_wdata_i,
  output logic [NS-1:0] reg_rdata_o,
  output logic          irq_noncrit_o,
  output logic          irq_crit_o
);
  logic [NS-1:0] sync_q, prev_q, set_v;
  logic [NS-1:0] status_q, enable_q, crit_q, pol_q, trig_q;

  irq_hub_sync #(.W(NS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (irq_src_i),
    .q_o    (sync_q),
    .prev_o (prev_q)
  );

  irq_hub_detect #(.W(NS)) u_detect (
    .sync_i (sync_q),
    .prev_i (prev_q),
    .trig_i (trig_q),
    .pol_i  (pol_q),
    .set_o  (set_v)
  );

  irq_hub_regs #(.W(NS), .AW(AW)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (reg_addr_i),
    .wr_i     (reg_wr_i),
    .rd_i     (reg_rd_i),
    .wdata_i  (reg_wdata_i),
    .set_i    (set_v),
    .rdata_o  (reg_rdata_o),
    .status_o (status_q),
    .enable_o (enable_q),
    .crit_o   (crit_q),
    .pol_o    (pol_q),
    .trig_o   (trig_q)
  );

  irq_hub_outs #(.W(NS)) u_outs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .status_i  (status_q),
    .enable_i  (enable_q),
    .crit_i    (crit_q),
    .noncrit_o (irq_noncrit_o),
    .crit_o    (irq_crit_o)
  );
endmodule

// File: rtl/irq_hub32_chk.sv
module irq_hub32_chk #(
  parameter int NS = 32,
  parameter int AW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] reg_addr_i,
  input logic          reg_rd_i,
  input logic [NS-1:0] reg_rdata_o,
  input logic          irq_noncrit_o,
  input logic          irq_crit_o,
  input logic [NS-1:0] status_q,
  input logic [NS-1:0] enable_q,
  input logic [NS-1:0] trig_q,
  input logic [NS-1:0] pol_q,
  input logic [NS-1:0] sync_q
);
  assert_rdata_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_rd_i |-> reg_rdata_o == '0);

  assert_unmapped_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && (reg_addr_i == AW'(1) || reg_addr_i >= AW'(7))) |-> reg_rdata_o == '0);

  assert_masked_subset_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && reg_addr_i == AW'(6)) |->
      ((reg_rdata_o & ~status_q) == '0 && (reg_rdata_o & ~enable_q) == '0));

  assert_level_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~$past(trig_q)) & ~($past(sync_q) ^ $past(pol_q)) & ~status_q) == '0);

  assert_disabled_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(enable_q) == '0) |-> (!irq_noncrit_o && !irq_crit_o));
endmodule

bind irq_hub32 irq_hub32_chk #(.NS(NS), .AW(AW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .reg_addr_i    (reg_addr_i),
  .reg_rd_i      (reg_rd_i),
  .reg_rdata_o   (reg_rdata_o),
  .irq_noncrit_o (irq_noncrit_o),
  .irq_crit_o    (irq_crit_o),
  .status_q      (status_q),
  .enable_q      (enable_q),
  .trig_q        (trig_q),
  .pol_q         (pol_q),
  .sync_q        (sync_q)
);

// File: tb/irq_hub32_tb_top.sv
`timescale 1ns/1ps
module irq_hub32_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq = '0;
  logic [3:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        nc_o, c_o;

  int n_checks = 0;
  int n_err    = 0;
  bit done     = 0;

  always #2.5 clk = ~clk;

  irq_hub32 dut_i (
    .clk_i(clk), .rst_ni(rst_n), .irq_src_i(irq), .reg_addr_i(addr),
    .reg_wr_i(wr), .reg_rd_i(rd), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_noncrit_o(nc_o), .irq_crit_o(c_o)
  );

  // Behavioural reference model, advanced on every rising clock
  logic [31:0] m_s1, m_s2, m_prev, m_stat, m_en, m_crit, m_pol, m_trig, nstat;
  logic        m_nc, m_c;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_prev = '0; m_stat = '0;
      m_en = '0; m_crit = '0; m_pol = '1; m_trig = '0;
      m_nc = 1'b0; m_c = 1'b0;
    end else begin
      nstat = m_stat;
      if (wr && addr == 4'h0) nstat = nstat & ~wdata;
      for (int n = 0; n < 32; n++) begin
        int b;
        bit hit;
        b = 31 - n;
        if (m_trig[b])
          hit = m_pol[b] ? (m_s2[b] && !m_prev[b]) : (!m_s2[b] && m_prev[b]);
        else
          hit = (m_s2[b] == m_pol[b]);
        if (hit) nstat[b] = 1'b1;
      end
      m_nc = |(m_stat & m_en & ~m_crit);
      m_c  = |(m_stat & m_en & m_crit);
      if (wr) begin
        case (addr)
          4'h2: m_en   = wdata;
          4'h3: m_crit = wdata;
          4'h4: m_pol  = wdata;
          4'h5: m_trig = wdata;
          default: ;
        endcase
      end
      m_prev = m_s2; m_s2 = m_s1; m_s1 = irq;
      m_stat = nstat;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_rdata();
    if (!rd) return '0;
    case (addr)
      4'h0: return m_stat;
      4'h2: return m_en;
      4'h3: return m_crit;
      4'h4: return m_pol;
      4'h5: return m_trig;
      4'h6: return m_stat & m_en;
      default: return '0;
    endcase
  endfunction

  // Per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R8 noncrit output", {31'b0, nc_o}, {31'b0, m_nc});
      chk("R8 crit output", {31'b0, c_o}, {31'b0, m_c});
      if (!rd)                   chk("R10 idle read bus", rdata, model_rdata());
      else if (addr == 4'h0)     chk("R3/R6 status read", rdata, model_rdata());
      else if (addr == 4'h6)     chk("R7 masked read", rdata, model_rdata());
      else if (addr == 4'h1 || addr >= 4'h7) chk("R9 unmapped read", rdata, model_rdata());
      else                       chk("R2 config read", rdata, model_rdata());
    end
  end

  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic wreg(input logic [3:0] a, input logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); #1;
    wr = 1'b0; wdata = '0;
  endtask

  task automatic rreg(input logic [3:0] a, input logic [31:0] exp, input string tag);
    rd = 1'b1; addr = a;
    #1 chk(tag, rdata, exp);
    @(negedge clk); #1;
    rd = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_checks++; n_err++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; #1;
    // R2 reset state
    chk("R2 noncrit after reset", {31'b0, nc_o}, 32'h0);
    chk("R2 crit after reset", {31'b0, c_o}, 32'h0);
    rreg(4'h0, 32'h0, "R2 status reset");
    rreg(4'h2, 32'h0, "R2 enable reset");
    rreg(4'h3, 32'h0, "R2 routing reset");
    rreg(4'h4, 32'hFFFF_FFFF, "R2 sense reset");
    rreg(4'h5, 32'h0, "R2 trigger reset");

    // R1/R5 level source 0 lands in bit 31
    wreg(4'h2, 32'hFFFF_FFFF);
    irq[31] = 1'b1; idle(5);
    rreg(4'h0, 32'h8000_0000, "R1 source 0 at bit 31");
    chk("R8 ordinary request raised", {31'b0, nc_o}, 32'h1);
    chk("R8 critical request idle", {31'b0, c_o}, 32'h0);
    rreg(4'h6, 32'h8000_0000, "R7 masked view");

    // R5 clear ineffective while active, also when disabled
    wreg(4'h0, 32'h8000_0000); idle(3);
    rreg(4'h0, 32'h8000_0000, "R5 level survives clear");
    wreg(4'h2, 32'h0);
    wreg(4'h0, 32'h8000_0000); idle(3);
    rreg(4'h0, 32'h8000_0000, "R5 level survives clear while disabled");
    chk("R8 request low when disabled", {31'b0, nc_o}, 32'h0);

    // R3 write-one clears, write-zero keeps
    irq[31] = 1'b0; irq[30] = 1'b1; idle(5);
    irq[30] = 1'b0; idle(5);
    rreg(4'h0, 32'hC000_0000, "R3 two pending");
    wreg(4'h0, 32'h4000_0000); idle(2);
    rreg(4'h0, 32'h8000_0000, "R3 zero bits untouched");
    wreg(4'h0, 32'h8000_0000); idle(2);
    rreg(4'h0, 32'h0, "R3 cleared");

    // R4 rising edge on source 4 (bit 27), routed critical
    wreg(4'h5, 32'h0800_0000);
    wreg(4'h3, 32'h0800_0000);
    wreg(4'h2, 32'h0800_0000);
    irq[27] = 1'b1; idle(5);
    rreg(4'h0, 32'h0800_0000, "R4 rising edge captured");
    chk("R8 critical request raised", {31'b0, c_o}, 32'h1);
    chk("R8 ordinary request idle", {31'b0, nc_o}, 32'h0);
    wreg(4'h0, 32'h0800_0000); idle(3);
    rreg(4'h0, 32'h0, "R4 steady high does not re-set");

    // R4 falling edge on source 5 (bit 26); R6 recorded while disabled
    wreg(4'h5, 32'h0C00_0000);
    wreg(4'h4, 32'hFBFF_FFFF);
    irq[26] = 1'b1; idle(5);
    rreg(4'h0, 32'h0, "R4 rise ignored with sense 0");
    irq[26] = 1'b0; idle(5);
    rreg(4'h0, 32'h0400_0000, "R4 falling edge captured");
    chk("R6 disabled pending makes no request", {31'b0, nc_o}, 32'h0);
    wreg(4'h2, 32'h0C00_0000); idle(2);
    chk("R6 request after enabling", {31'b0, nc_o}, 32'h1);
    wreg(4'h0, 32'h0400_0000); idle(2);

    // R7 masked is read-only; R9 unmapped offsets
    wreg(4'h6, 32'hFFFF_FFFF);
    wreg(4'h1, 32'hFFFF_FFFF);
    wreg(4'h7, 32'hFFFF_FFFF);
    wreg(4'h8, 32'hFFFF_FFFF);
    wreg(4'hF, 32'hFFFF_FFFF);
    idle(2);
    rreg(4'h0, 32'h0, "R7 write to masked leaves status");
    rreg(4'h2, 32'h0C00_0000, "R9 enable intact");
    rreg(4'h3, 32'h0800_0000, "R9 routing intact");
    rreg(4'h4, 32'hFBFF_FFFF, "R9 sense intact");
    rreg(4'h5, 32'h0C00_0000, "R9 trigger intact");
    rreg(4'h1, 32'h0, "R9 offset 1 reads zero");
    rreg(4'h7, 32'h0, "R9 offset 7 reads zero");
    rreg(4'h9, 32'h0, "R9 offset 9 reads zero");

    // R6 set wins over a clear in the same cycle (level source 2, bit 29)
    irq[29] = 1'b1; idle(4);
    wr = 1'b1; addr = 4'h0; wdata = 32'h2000_0000; idle(6);
    wr = 1'b0; wdata = '0;
    rreg(4'h0, 32'h2000_0000, "R6 set beats clear");
    irq[29] = 1'b0; idle(4);
    wreg(4'h0, 32'h2000_0000); idle(1);

    // R6 edge hit during continuous clears, watched on every cycle
    irq[27] = 1'b0; idle(4);
    rd = 1'b1; wr = 1'b1; addr = 4'h0; wdata = 32'h0800_0000;
    irq[27] = 1'b1; idle(6);
    rd = 1'b0; wr = 1'b0; wdata = '0; idle(1);
    chk("R10 read bus zero when idle", rdata, 32'h0);

    idle(3);
    finish_run();
  end
endmodule